// File: doc/BRIEF.md
# Triggered State Trace Recorder

The recorder sits beside an engine that runs round by round and keeps a short history of a wide probe bus for offline comparison against a fault-free run. While it is armed, a one-cycle start pulse from the engine fires a capture. The recorder then writes a fixed burst of consecutive probe samples into an internal buffer, one row per clock of the monitored clock domain. When the burst is complete the buffer is frozen and a done flag is raised. A host then fetches the rows one at a time through a request/grant read port that addresses a row by its sample index.

The probe bus is built from four equal lanes: the plain state, its dual-rail form, the key and its dual-rail form. The recorder only observes. It drives nothing back into the engine and adds no load beyond the probe fan-out. Start pulses that arrive while a burst is running, or after it has finished but before the host re-arms the unit, are discarded. This keeps a finished trace intact until it has been read.

Top module: `trace_capture`

## Requirements
- R1: After reset, busy_o, done_o, rd_gnt_o and rd_dvalid_o are all 0 and the unit is armed.
- R2: A trig_i pulse sampled at a clock edge while armed stores the probe_i value of that cycle as row 0. Row i holds probe_i from i cycles later, for rows 0 to DEPTH-1 (64 by default).
- R3: busy_o is 1 from the edge that takes the trigger until the edge that writes row DEPTH-1. At that edge busy_o falls and done_o rises, DEPTH-1 clock edges after the trigger edge.
- R4: trig_i pulses during a capture are ignored. The burst neither restarts nor lengthens, and every row still holds its original sample.
- R5: trig_i pulses while done_o is 1 are ignored. done_o stays 1 and the stored rows are unchanged.
- R6: rearm_i sampled while done_o is 1 clears done_o at that edge and arms the unit, so the next trig_i starts a new burst. rearm_i has no effect during a capture.
- R7: rd_gnt_o is 1 only while done_o is 1. A read request is accepted at an edge where rd_req_i and rd_gnt_o are both 1. After an accepted request, rd_dvalid_o is 1 in the following cycle, with rd_data_o equal to the row at rd_addr_i. rd_dvalid_o is 0 in every other cycle, including after requests made while not done.
- R8: All PROBE_W = 4 × 96 bits are stored and returned. Lane j occupies bits [96·j+95 : 96·j], and the lanes are kept independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored engine clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start pulse from the engine |
| rearm_i | input | 1 | Clears done and arms a new capture |
| probe_i | input | 384 | Probe bus, four 96-bit lanes |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Buffer full and frozen |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | 6 | Row (sample index) to read |
| rd_gnt_o | output | 1 | Read request can be accepted |
| rd_dvalid_o | output | 1 | rd_data_o holds the requested row |
| rd_data_o | output | 384 | Read data |

## Verification
The probe bus carries a pattern that counts with the cycle number. Each lane is scrambled with its own salt, so a row shifted by one sample, a lane swapped with another or a stuck bit shows up as a mismatch in a specific row. Directed runs read all 64 rows in order. Further runs inject extra start pulses and re-arm pulses at random points during a capture and after it. A restarted or stretched burst then appears as a wrong base cycle, and an overwritten frozen buffer appears as rows from a later cycle. Read requests issued while the unit is armed or busy confirm that no data-valid strobe is produced without a grant.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FULL  = 2'd2
  } trc_state_t;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl import trc_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          rearm,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  trc_state_t    state;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARMED;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_ARMED: if (trig) begin
          state <= ST_CAPT;
          cnt   <= AW'(1);
        end
        ST_CAPT: begin
          cnt <= cnt + AW'(1);
          if (cnt == LAST) state <= ST_FULL;
        end
        ST_FULL: if (rearm) state <= ST_ARMED;
        default: state <= ST_ARMED;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == ST_CAPT) || (state == ST_ARMED && trig);
    wr_addr = (state == ST_CAPT) ? cnt : '0;
  end

  assign busy = (state == ST_CAPT);
  assign done = (state == ST_FULL);

  // R3: a burst runs on until the last row
  a_r3_burst_runs: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && cnt != LAST) |=> state == ST_CAPT);
  // R3: the last row ends the burst
  a_r3_burst_ends: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && cnt == LAST) |=> state == ST_FULL);
  // R4 / R6: neither trigger nor rearm leaves the capture state early
  a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT) |=> state != ST_ARMED);
  // R5: a full buffer stays frozen until rearm
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FULL && !rearm) |=> state == ST_FULL);
  // R6: rearm while full arms the unit
  a_r6_rearm_arms: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FULL && rearm) |=> state == ST_ARMED);
endmodule

// File: rtl/trc_mem.sv
module trc_mem #(
  parameter int W     = 384,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_rdport.sv
module trc_rdport #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frozen,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          gnt,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          dvalid
);
  assign gnt     = frozen;
  assign rd_en   = req && frozen;
  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) dvalid <= 1'b0;
    else     dvalid <= rd_en;
  end

  // R7: an accepted request yields data in the next cycle
  a_r7_dvalid_follows: assert property (@(posedge clk) disable iff (rst)
    (req && gnt) |=> dvalid);
  // R7: no data strobe without an accepted request
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(req && gnt) |=> !dvalid);
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int LANE_W = 96,
  parameter int LANES  = 4,
  parameter int DEPTH  = 64,
  localparam int PROBE_W = LANE_W * LANES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_i,
  input  logic               rearm_i,
  input  logic [PROBE_W-1:0] probe_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic               rd_req_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic               rd_gnt_o,
  output logic               rd_dvalid_o,
  output logic [PROBE_W-1:0] rd_data_o
);
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  trc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig_i), .rearm(rearm_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy_o), .done(done_o)
  );

  // one memory per lane, so each lane maps to its own RAM columns
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    trc_mem #(.W(LANE_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .we(wr_en), .waddr(wr_addr),
      .wdata(probe_i[g*LANE_W +: LANE_W]),
      .re(rd_en), .raddr(rd_addr),
      .rdata(rd_data_o[g*LANE_W +: LANE_W])
    );
  end

  trc_rdport #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .frozen(done_o), .req(rd_req_i), .addr(rd_addr_i),
    .gnt(rd_gnt_o), .rd_en(rd_en), .rd_addr(rd_addr), .dvalid(rd_dvalid_o)
  );

  // R1 / R3: never busy and done together
  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  // R7: grant only on a frozen buffer
  a_r7_gnt_when_done: assert property (@(posedge clk) disable iff (rst)
    rd_gnt_o |-> done_o);
endmodule

// File: tb/tb_trace_capture.sv
`timescale 1ns/1ps
module tb_trace_capture;
  localparam int LANE_W = 96, LANES = 4, DEPTH = 64;
  localparam int PW = LANE_W * LANES;

  logic clk = 0, rst = 1, trig = 0, rearm = 0, rd_req = 0;
  logic [5:0] rd_addr = '0;
  logic busy, done, gnt, dvalid;
  logic [PW-1:0] rdata, probe;
  int unsigned cyc = 0, salt = 0;
  int nvec = 0, nfail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // counting pattern, each 32-bit word salted by lane and word index
  function automatic logic [PW-1:0] mk(int unsigned k);
    logic [PW-1:0] v;
    for (int j = 0; j < LANES * 3; j++)
      v[j*32 +: 32] = (k * 32'h9E3779B1) ^ salt ^ (j * 32'h01010101) ^ k;
    return v;
  endfunction

  assign probe = mk(cyc);

  trace_capture #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .trig_i(trig), .rearm_i(rearm), .probe_i(probe),
    .busy_o(busy), .done_o(done), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_gnt_o(gnt), .rd_dvalid_o(dvalid), .rd_data_o(rdata)
  );

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // R7 read: request at one negedge, check data at the next
  task automatic rd(int a, logic [PW-1:0] exp, string req);
    @(negedge clk);
    rd_req = 1; rd_addr = 6'(a);
    chk("R7 gnt", PW'(gnt), PW'(1));
    @(negedge clk);
    rd_req = 0;
    chk("R7 dvalid", PW'(dvalid), PW'(1));
    chk(req, rdata, exp);
  endtask

  // capture, with optional extra trigger/rearm after edge injs/injr
  task automatic capture(int injs, int injr, output int unsigned k0);
    @(negedge clk);
    trig = 1; k0 = cyc;
    @(negedge clk);
    trig = 0;
    chk("R3 busy after trigger", PW'({busy, done}), PW'(2'b10));
    for (int e = 1; e <= 63; e++) begin
      @(negedge clk);
      trig  = (e == injs);   // R4: ignored during capture
      rearm = (e == injr);   // R6: ignored during capture
      if (e == 62) chk("R3 still busy", PW'({busy, done}), PW'(2'b10));
      if (e == 63) chk("R3 done edge", PW'({busy, done}), PW'(2'b01));
    end
    trig = 0; rearm = 0;
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
    chk("R6 rearm clears done", PW'({busy, done, gnt}), PW'(0));
  endtask

  initial begin
    int unsigned k0, k1;
    salt = $urandom(32'd20240611);
    salt = $urandom();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset", PW'({busy, done, gnt, dvalid}), PW'(0));

    // R7: request while armed gives no data
    rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R7 no dvalid while armed", PW'(dvalid), PW'(0));

    // directed capture, all rows in order (R2, R8)
    capture(0, 0, k0);
    for (int r = 0; r < DEPTH; r++) rd(r, mk(k0 + r), "R2 R8 row");

    // R5: trigger while full is ignored
    @(negedge clk); trig = 1; @(negedge clk); trig = 0;
    repeat (4) @(negedge clk);
    chk("R5 done held", PW'({busy, done}), PW'(2'b01));
    rd(0, mk(k0), "R5 row0 kept");
    rd(63, mk(k0 + 63), "R5 row63 kept");

    // R4/R6: extra trigger and rearm during capture
    do_rearm();
    capture(20, 40, k1);
    for (int r = 0; r < DEPTH; r++) rd(r, mk(k1 + r), "R4 R6 row");

    // R7: request while busy gives no data
    do_rearm();
    @(negedge clk); trig = 1; @(negedge clk); trig = 0;
    rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R7 no dvalid while busy", PW'(dvalid), PW'(0));
    repeat (70) @(negedge clk);
    chk("R3 done after busy read", PW'(done), PW'(1));

    // random runs
    for (int run = 0; run < 4; run++) begin
      int injs, injr;
      do_rearm();
      repeat ($urandom_range(0, 9)) @(negedge clk);
      injs = $urandom_range(1, 62);
      injr = $urandom_range(1, 62);
      capture(injs, injr, k0);
      for (int n = 0; n < 16; n++) begin
        int a;
        a = $urandom_range(0, DEPTH - 1);
        rd(a, mk(k0 + a), "R2 R4 random row");
      end
      rd(0, mk(k0), "R2 first row");
      rd(DEPTH - 1, mk(k0 + DEPTH - 1), "R2 last row");
    end

    summary();
    $finish;
  end

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end
endmodule